// File: doc/BRIEF.md
# Programmable Horizontal Line Timer

This block produces the per-line horizontal timing of a raster video output directly from a fast system clock. A free-running tick counter repeats every N ticks. Three compare points inside each line are programmed in system-clock ticks: where the sync pulse ends, where the back porch ends and pixels may start, and an optional early warning some ticks before that point. There is no fixed pixel clock. The pixel gate output is meant to start and stop a separate pixel divider or fetch engine.

Software programs five registers through a simple write port. The block holds every value in a staging copy and moves it into the working copy at the next line reload, so a line is never timed with a mix of old and new values. While the timer is disabled, the counter waits a few ticks short of the wrap point. Once it is enabled, the first line begins almost at once.

Top module: `hsync_timer`

## Requirements
- R1: With period register (write select 0) holding N, the tick counter runs 0..N-1 and wraps to 0, so consecutive line-start pulses are exactly N cycles apart.
- R2: The sync pulse is active from the reload tick (count 0) up to and including count S-1, where S is the sync-end register (write select 1), and inactive for the rest of the line.
- R3: Control register (write select 4) bit 0 selects the sync level: 1 drives `hsync_o` high while active and low while inactive, 0 does the reverse.
- R4: `pix_gate_o` is low from the reload up to count B-1 and high from count B through N-1, where B is the back-porch-end register (write select 2).
- R5: With control bit 1 set, `early_o` is a one-cycle pulse at count B-K, where K is the early-offset register (write select 3). It stays low when control bit 1 is clear or when K exceeds B.
- R6: `line_start_o` is a one-cycle pulse on the tick at which the counter reloads to 0.
- R7: While disabled, the counter waits at N-LEAD (LEAD=3). The first `line_start_o` is seen LEAD cycles after `enable` rises, and before it the gate stays low and sync stays inactive.
- R8: A write while running goes to a staging copy and governs timing only from the next reload. A write issued on the reload cycle itself first applies one line later. While the timer is disabled, a write applies on the next cycle.
- R9: While `enable` is low, `hsync_o` sits at its inactive level and `pix_gate_o`, `early_o` and `line_start_o` are low.
- R10: After reset the registers hold N=2669, S=320, B=480, K=0 and control=0 (active-low sync, early event off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the line counter when high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select: 0 period, 1 sync end, 2 back-porch end, 3 early offset, 4 control |
| wr_data | input | 12 | Write value; the control register uses bits 1:0 |
| hsync_o | output | 1 | Horizontal sync pin with programmable level |
| pix_gate_o | output | 1 | Pixel enable gate |
| line_start_o | output | 1 | One-cycle pulse on counter reload |
| early_o | output | 1 | One-cycle pulse ahead of pixel start |

## Verification
Two things can happen on the same edge: a register write and the line reload that moves the staging copy into the working copy. The bench issues a period write on the exact cycle where the count equals N-1. It then checks that the line just starting still has the old length and that the line after it has the new length. A second case places a group of writes early in a running line and checks that the line still ends on its old period and only the next line uses the new sync, gate and period values.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

    localparam int TICK_W = 12;

    typedef logic [TICK_W-1:0] tick_t;

    typedef struct packed {
        tick_t period;
        tick_t sync_end;
        tick_t bp_end;
        tick_t early_off;
        logic  pol_high;
        logic  early_en;
    } hcfg_t;

    typedef enum logic [2:0] {
        SEL_PERIOD = 3'd0,
        SEL_SYNC   = 3'd1,
        SEL_BPORCH = 3'd2,
        SEL_EARLY  = 3'd3,
        SEL_CTRL   = 3'd4
    } wsel_e;

    function automatic hcfg_t apply_write(hcfg_t cur, wsel_e sel, tick_t data);
        hcfg_t nxt;
        nxt = cur;
        case (sel)
            SEL_PERIOD: nxt.period    = data;
            SEL_SYNC:   nxt.sync_end  = data;
            SEL_BPORCH: nxt.bp_end    = data;
            SEL_EARLY:  nxt.early_off = data;
            SEL_CTRL: begin
                nxt.pol_high = data[0];
                nxt.early_en = data[1];
            end
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/hsync_cfg_regs.sv
module hsync_cfg_regs
    import hsync_pkg::*;
#(
    parameter int DEF_PERIOD = 2669,
    parameter int DEF_SYNC   = 320,
    parameter int DEF_BPORCH = 480
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic [2:0] wr_sel,
    input  tick_t wr_data,
    input  logic  commit,
    output hcfg_t staged_o,
    output hcfg_t active_o
);
    localparam hcfg_t CFG_RESET = '{
        period:    tick_t'(DEF_PERIOD),
        sync_end:  tick_t'(DEF_SYNC),
        bp_end:    tick_t'(DEF_BPORCH),
        early_off: '0,
        pol_high:  1'b0,
        early_en:  1'b0
    };

    hcfg_t staged_q, active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= CFG_RESET;
            active_q <= CFG_RESET;
        end else begin
            if (wr_en)
                staged_q <= apply_write(staged_q, wsel_e'(wr_sel), wr_data);
            if (commit)
                active_q <= staged_q;
        end
    end

    assign staged_o = staged_q;
    assign active_o = active_q;
endmodule

// File: rtl/hsync_line_counter.sv
module hsync_line_counter
    import hsync_pkg::*;
#(
    parameter int LEAD = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  enable,
    input  tick_t period_act,
    input  tick_t period_staged,
    output tick_t cnt_o,
    output logic  wrap_o,
    output logic  started_o
);
    localparam tick_t LEAD_T = tick_t'(LEAD);

    tick_t cnt_q;
    logic  started_q;
    logic  wrap;

    assign wrap = enable && (cnt_q == period_act - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            started_q <= 1'b0;
        end else if (!enable) begin
            cnt_q     <= period_staged - LEAD_T;
            started_q <= 1'b0;
        end else if (wrap) begin
            cnt_q     <= '0;
            started_q <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o     = cnt_q;
    assign wrap_o    = wrap;
    assign started_o = started_q;
endmodule

// File: rtl/hsync_decode.sv
module hsync_decode
    import hsync_pkg::*;
(
    input  logic  enable,
    input  logic  started,
    input  tick_t cnt,
    input  hcfg_t cfg,
    output logic  hsync_o,
    output logic  pix_gate_o,
    output logic  line_start_o,
    output logic  early_o
);
    logic              live;
    logic              sync_act;
    logic [TICK_W:0]   early_pt;

    assign live     = enable && started;
    assign sync_act = live && (cnt < cfg.sync_end);
    assign early_pt = {1'b0, cfg.bp_end} - {1'b0, cfg.early_off};

    assign hsync_o      = cfg.pol_high ? sync_act : !sync_act;
    assign pix_gate_o   = live && (cnt >= cfg.bp_end);
    assign line_start_o = live && (cnt == '0);
    assign early_o      = live && cfg.early_en && !early_pt[TICK_W]
                          && (cnt == early_pt[TICK_W-1:0]);
endmodule

// File: rtl/hsync_timer.sv
module hsync_timer
    import hsync_pkg::*;
#(
    parameter int DEF_PERIOD = 2669,
    parameter int DEF_SYNC   = 320,
    parameter int DEF_BPORCH = 480,
    parameter int LEAD       = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [11:0] wr_data,
    output logic        hsync_o,
    output logic        pix_gate_o,
    output logic        line_start_o,
    output logic        early_o
);
    hcfg_t cfg_staged, cfg_act;
    tick_t cnt;
    logic  wrap, started, commit;

    assign commit = !enable || wrap;

    hsync_cfg_regs #(
        .DEF_PERIOD(DEF_PERIOD),
        .DEF_SYNC  (DEF_SYNC),
        .DEF_BPORCH(DEF_BPORCH)
    ) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .commit  (commit),
        .staged_o(cfg_staged),
        .active_o(cfg_act)
    );

    hsync_line_counter #(.LEAD(LEAD)) cnt_i (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .period_act   (cfg_act.period),
        .period_staged(cfg_staged.period),
        .cnt_o        (cnt),
        .wrap_o       (wrap),
        .started_o    (started)
    );

    hsync_decode dec_i (
        .enable      (enable),
        .started     (started),
        .cnt         (cnt),
        .cfg         (cfg_act),
        .hsync_o     (hsync_o),
        .pix_gate_o  (pix_gate_o),
        .line_start_o(line_start_o),
        .early_o     (early_o)
    );

    // R1: a running count never reaches the working period
    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (rst)
        started |-> (cnt < cfg_act.period));

    // R6: the reload pulse lasts a single cycle
    assert_line_start_single_R6: assert property (@(posedge clk) disable iff (rst)
        line_start_o |=> !line_start_o);

    // R4: the gate only drops at a reload or when stopped
    assert_gate_falls_at_reload_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(pix_gate_o) |-> (line_start_o || !enable));

    // R5: the early event lasts a single cycle
    assert_early_single_R5: assert property (@(posedge clk) disable iff (rst)
        early_o |=> !early_o);

    // R8: working timing only changes at a line boundary while running
    assert_cfg_stable_midline_R8: assert property (@(posedge clk) disable iff (rst)
        (enable && $past(enable) && !line_start_o) |-> $stable(cfg_act));

    // R9: stopped timer holds sync at its inactive level
    assert_sync_idle_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (hsync_o == !cfg_act.pol_high && !pix_gate_o));
endmodule

// File: tb/hsync_timer_tb.sv
module hsync_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst, enable, wr_en;
    logic [2:0]  wr_sel;
    logic [11:0] wr_data;
    logic        hsync_o, pix_gate_o, line_start_o, early_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    hsync_timer dut_i (
        .clk(clk), .rst(rst), .enable(enable),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hsync_o(hsync_o), .pix_gate_o(pix_gate_o),
        .line_start_o(line_start_o), .early_o(early_o)
    );

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wreg(input int sel, input int data);
        wr_en   = 1'b1;
        wr_sel  = 3'(sel);
        wr_data = 12'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic stop_timer();
        enable = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_ls();
        for (int i = 0; i < 4000 && !line_start_o; i++) @(negedge clk);
        chk("R6 line start seen", int'(line_start_o), 1);
    endtask

    // Called at the negedge where line_start_o is high; checks one full line.
    task automatic run_line(input int per, input int sy, input int bp,
                            input int early_at, input bit pol);
        for (int i = 0; i < per; i++) begin
            chk("R2/R3 sync level", int'(hsync_o), int'(pol ? (i < sy) : !(i < sy)));
            chk("R4 gate", int'(pix_gate_o), int'(i >= bp));
            chk("R5 early", int'(early_o), int'(i == early_at));
            chk("R6 line start", int'(line_start_o), int'(i == 0));
            @(negedge clk);
        end
        chk("R1 period wrap", int'(line_start_o), 1);
    endtask

    task automatic test_reset();
        for (int i = 0; i < 4; i++) begin
            chk("R10 reset sync inactive high", int'(hsync_o), 1);
            chk("R9 gate low while off", int'(pix_gate_o), 0);
            chk("R9 line start low while off", int'(line_start_o), 0);
            chk("R9 early low while off", int'(early_o), 0);
            @(negedge clk);
        end
    endtask

    task automatic test_default_startup();
        int n;
        enable = 1'b1;
        n = 0;
        while (!line_start_o && n < 10) begin
            @(negedge clk);
            n++;
            if (!line_start_o) begin
                chk("R7 gate low before first line", int'(pix_gate_o), 0);
                chk("R7 sync inactive before first line", int'(hsync_o), 1);
            end
        end
        chk("R7 first reload delay", n, 3);
        run_line(2669, 320, 480, -1, 1'b0);  // R10 defaults, R1
        stop_timer();
    endtask

    task automatic test_program_lowpol();
        wreg(0, 20); wreg(1, 4); wreg(2, 8); wreg(3, 3); wreg(4, 2);
        enable = 1'b1;
        wait_ls();
        run_line(20, 4, 8, 5, 1'b0);
        run_line(20, 4, 8, 5, 1'b0);
        stop_timer();
    endtask

    task automatic test_high_pol();
        wreg(0, 16); wreg(1, 3); wreg(2, 6); wreg(3, 0); wreg(4, 3);
        enable = 1'b1;
        wait_ls();
        run_line(16, 3, 6, 6, 1'b1);
        stop_timer();
        for (int i = 0; i < 5; i++) begin
            chk("R9/R3 idle level with high polarity", int'(hsync_o), 0);
            chk("R9 gate low after stop", int'(pix_gate_o), 0);
            chk("R9 line start low after stop", int'(line_start_o), 0);
            @(negedge clk);
        end
    endtask

    task automatic test_early_off();
        wreg(0, 20); wreg(1, 4); wreg(2, 8); wreg(3, 3); wreg(4, 0);
        enable = 1'b1;
        wait_ls();
        run_line(20, 4, 8, -1, 1'b0);   // R5 disabled by control bit 1
        stop_timer();
        wreg(3, 9); wreg(4, 2);
        enable = 1'b1;
        wait_ls();
        run_line(20, 4, 8, -1, 1'b0);   // R5 offset beyond back-porch end
        stop_timer();
    endtask

    task automatic test_midline_update();
        int n;
        wreg(0, 20); wreg(1, 4); wreg(2, 8); wreg(4, 0);
        enable = 1'b1;
        wait_ls();
        wreg(0, 12); wreg(1, 2); wreg(2, 4);
        n = 3;
        while (n < 40) begin
            chk("R8 old gate kept in current line", int'(pix_gate_o), int'(n >= 8));
            chk("R8 old sync kept in current line", int'(hsync_o), int'(!(n < 4)));
            @(negedge clk);
            n++;
            if (line_start_o) break;
        end
        chk("R8 current line keeps old period", n, 20);
        run_line(12, 2, 4, -1, 1'b0);
    endtask

    task automatic test_reload_collision();
        // running with period 12 from the previous test, at line start
        for (int i = 0; i < 11; i++) @(negedge clk);
        wreg(0, 18);                    // write lands on the reload edge
        chk("R8 reload on collision cycle", int'(line_start_o), 1);
        run_line(12, 2, 4, -1, 1'b0);   // R8 line just begun uses old period
        run_line(18, 2, 4, -1, 1'b0);   // R8 following line uses new period
        stop_timer();
    endtask

    initial begin
        rst = 1'b1; enable = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_default_startup();
        test_program_lowpol();
        test_high_pol();
        test_early_off();
        test_midline_update();
        test_reload_collision();
        finish_run();
    end
endmodule